// File: doc/BRIEF.md
# Software Self-Test Manager

This block sits beside a processor core and runs a software-based self-test on it without any change to the core. A tester drives it through a narrow serial command path modelled on an IEEE 1500 style wrapper: it shifts in a fixed-length command frame and then commits it with an update strobe. Four commands exist. One writes a word of test program into code memory. One starts the test. One reads back a status word. One reads back the result signature.

To upload a word, the manager takes over the bus path into code memory for one cycle and performs the write itself, so the processor plays no part. The test routine is installed as an interrupt service routine, and a run command starts it by raising an interrupt request. While the routine runs, every word it writes to a dedicated result port is folded into a 16-bit multiple-input signature register. A fixed end-of-test marker written to that port closes the run. A run command can also arm a debug trigger: a second interrupt fires when a chosen address appears on the processor bus.

Top module: `sbst_mgr`

## Requirements
- R1: A command frame is FRAME_W = 2 + ADDR_W + DATA_W bits, shifted in on `tdi` least significant bit first, one bit per cycle with `shift_en` high. The frame holds the opcode at bits [1:0], the address at [ADDR_W+1:2] and the data above that. The frame acts on the clock edge where `update_en` is high. Opcodes: 0 = load word, 1 = run, 2 = read status, 3 = read signature.
- R2: An accepted load command makes `mem_grant` and `mem_we` high for exactly the one cycle after the update edge, with the frame's address on `mem_addr` and its data on `mem_wdata`. A load command issued while a test is running is ignored, and the grant stays low.
- R3: An accepted run command raises `irq` at the update edge. The request stays high until a cycle where `irq_ack` is high, and it is low from the next cycle on.
- R4: The signature resets to 0 when a run is accepted. While running, each cycle with `res_we` high replaces the signature S with ((S<<1) ^ (S[15] ? 0x1021 : 0) ^ `res_data`), truncated to 16 bits, which is the polynomial x^16+x^12+x^5+1. Result writes made while not running leave the signature unchanged.
- R5: A result-port write of END_MARK (default 0xA5C3) while running is compacted into the signature and moves the state to done.
- R6: After a read command is updated, the 16-bit word appears on `tdo` bit 0 first. Each further `shift_en` cycle advances one bit. A signature read while running returns the partial signature and leaves the run and its state unchanged.
- R7: A run command issued before any word has been loaded is ignored: `irq` stays low, the state stays idle and the error flag is set. The next accepted run clears the flag.
- R8: The status word is: bits [1:0] state (0 idle, 1 loading, 2 running, 3 done), bit 2 error flag, bit 3 program-loaded flag, all other bits 0.
- R9: A run frame with data bit 0 set arms the debug trigger at the frame's address. The first later cycle with `bus_valid` high and `bus_addr` equal to that address raises `dbg_irq` on the next cycle and disarms the trigger. `dbg_irq` stays high until `dbg_ack`.
- R10: After reset the state is idle, both flags are clear, the signature is 0, and `mem_grant`, `mem_we`, `irq`, `dbg_irq` and `tdo` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tdi | input | 1 | Serial command data in |
| shift_en | input | 1 | Shift one command bit in and one readback bit out |
| update_en | input | 1 | Commit the shifted frame |
| tdo | output | 1 | Serial readback data out |
| mem_grant | output | 1 | Bus takeover toward code memory |
| mem_we | output | 1 | Code memory write strobe |
| mem_addr | output | ADDR_W | Code memory write address |
| mem_wdata | output | DATA_W | Code memory write data |
| irq | output | 1 | Self-test interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge from the processor |
| res_we | input | 1 | Result port write strobe |
| res_data | input | DATA_W | Result port data |
| bus_valid | input | 1 | Processor bus address valid |
| bus_addr | input | ADDR_W | Processor bus address |
| dbg_irq | output | 1 | Debug address-match interrupt |
| dbg_ack | input | 1 | Debug interrupt acknowledge |

## Verification
The bench builds the block with its defaults: 16-bit address and data, the 0x1021 feedback polynomial, an end marker of 0xA5C3 and the debug trigger generated in. This puts every opcode, the refused early run, the load refused during a run, a partial signature read mid-run and the armed trigger's one-shot firing within reach of short directed sequences. The signature width equals DATA_W, so a bench with 16-bit data checks the stated polynomial directly against its own model.

// File: rtl/sbst_pkg.sv
package sbst_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_RUN  = 2'd2,
      ST_DONE = 2'd3
   } sbst_state_e;

   typedef enum logic [1:0] {
      OP_LOAD = 2'd0,
      OP_RUN  = 2'd1,
      OP_STAT = 2'd2,
      OP_SIG  = 2'd3
   } sbst_op_e;

   localparam int OP_W = 2;

endpackage

// File: rtl/sbst_cmd_shift.sv
module sbst_cmd_shift #(
   parameter int FRAME_W = 34
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic               tdi,
   output logic [FRAME_W-1:0] frame
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         frame <= '0;
      else if (shift_en)
         frame <= {tdi, frame[FRAME_W-1:1]};
   end

endmodule

// File: rtl/sbst_readout.sv
module sbst_readout #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] word,
   input  logic         shift_en,
   output logic         tdo
);

   logic [W-1:0] out_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         out_sr <= '0;
      else if (load)
         out_sr <= word;
      else if (shift_en)
         out_sr <= {1'b0, out_sr[W-1:1]};
   end

   assign tdo = out_sr[0];

endmodule

// File: rtl/sbst_misr.sv
module sbst_misr #(
   parameter int         W    = 16,
   parameter logic [W-1:0] POLY = 16'h1021
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] din,
   output logic [W-1:0] sig
);

   logic [W-1:0] fb;
   logic [W-1:0] nxt;

   always_comb begin
      fb  = sig[W-1] ? POLY : '0;
      nxt = {sig[W-2:0], 1'b0} ^ fb ^ din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sig <= '0;
      else if (clr)
         sig <= '0;
      else if (step)
         sig <= nxt;
   end

endmodule

// File: rtl/sbst_ctrl.sv
module sbst_ctrl
   import sbst_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter int          DATA_W   = 16,
   parameter logic [DATA_W-1:0] END_MARK = 16'hA5C3,
   parameter bit          DBG_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  sbst_op_e          op,
   input  logic [ADDR_W-1:0] f_addr,
   input  logic [DATA_W-1:0] f_data,
   input  logic              res_we,
   input  logic [DATA_W-1:0] res_data,
   input  logic              irq_ack,
   input  logic              dbg_ack,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   output sbst_state_e       state,
   output logic              loaded,
   output logic              err,
   output logic              irq,
   output logic              dbg_irq,
   output logic              misr_clr,
   output logic              misr_step,
   output logic [ADDR_W-1:0] ld_addr,
   output logic [DATA_W-1:0] ld_data
);

   logic run_ok;
   logic load_ok;

   assign run_ok    = upd && (op == OP_RUN) && (state != ST_RUN) && loaded;
   assign load_ok   = upd && (op == OP_LOAD) && (state != ST_RUN);
   assign misr_clr  = run_ok;
   assign misr_step = (state == ST_RUN) && res_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         loaded  <= 1'b0;
         err     <= 1'b0;
         irq     <= 1'b0;
         ld_addr <= '0;
         ld_data <= '0;
      end else begin
         if (state == ST_LOAD)
            state <= ST_IDLE;
         if (irq_ack)
            irq <= 1'b0;
         if (load_ok) begin
            state   <= ST_LOAD;
            ld_addr <= f_addr;
            ld_data <= f_data;
            loaded  <= 1'b1;
         end
         if (upd && (op == OP_RUN) && (state != ST_RUN)) begin
            if (loaded) begin
               state <= ST_RUN;
               irq   <= 1'b1;
               err   <= 1'b0;
            end else begin
               err   <= 1'b1;
            end
         end
         if (misr_step && (res_data == END_MARK))
            state <= ST_DONE;
      end
   end

   generate
      if (DBG_EN) begin : g_dbg
         logic              armed;
         logic [ADDR_W-1:0] match;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               armed   <= 1'b0;
               match   <= '0;
               dbg_irq <= 1'b0;
            end else begin
               if (dbg_ack)
                  dbg_irq <= 1'b0;
               if (armed && bus_valid && (bus_addr == match)) begin
                  dbg_irq <= 1'b1;
                  armed   <= 1'b0;
               end
               if (run_ok) begin
                  armed <= f_data[0];
                  match <= f_addr;
               end
            end
         end
      end else begin : g_nodbg
         assign dbg_irq = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/sbst_mgr.sv
module sbst_mgr
   import sbst_pkg::*;
#(
   parameter int                ADDR_W   = 16,
   parameter int                DATA_W   = 16,
   parameter logic [DATA_W-1:0] POLY     = 16'h1021,
   parameter logic [DATA_W-1:0] END_MARK = 16'hA5C3,
   parameter bit                DBG_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tdi,
   input  logic              shift_en,
   input  logic              update_en,
   output logic              tdo,
   output logic              mem_grant,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              irq,
   input  logic              irq_ack,
   input  logic              res_we,
   input  logic [DATA_W-1:0] res_data,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              dbg_irq,
   input  logic              dbg_ack
);

   localparam int FRAME_W  = OP_W + ADDR_W + DATA_W;
   localparam int ADDR_LSB = OP_W;
   localparam int DATA_LSB = OP_W + ADDR_W;

   if (DATA_W < 4) begin : g_chk_w
      $error("sbst_mgr: DATA_W must hold the status word");
   end
   if (ADDR_W < 1) begin : g_chk_a
      $error("sbst_mgr: ADDR_W must be positive");
   end
   if (POLY[0] != 1'b1) begin : g_chk_p
      $error("sbst_mgr: feedback polynomial needs a constant term");
   end

   logic [FRAME_W-1:0] frame;
   sbst_op_e           op;
   sbst_state_e        state;
   logic               loaded;
   logic               err;
   logic               misr_clr;
   logic               misr_step;
   logic [DATA_W-1:0]  sig;
   logic [DATA_W-1:0]  status_w;
   logic [DATA_W-1:0]  rd_word;
   logic               rd_load;

   sbst_cmd_shift #(.FRAME_W(FRAME_W)) i_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .tdi      (tdi),
      .frame    (frame)
   );

   assign op = sbst_op_e'(frame[OP_W-1:0]);

   sbst_ctrl #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .END_MARK (END_MARK),
      .DBG_EN   (DBG_EN)
   ) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd       (update_en),
      .op        (op),
      .f_addr    (frame[ADDR_LSB +: ADDR_W]),
      .f_data    (frame[DATA_LSB +: DATA_W]),
      .res_we    (res_we),
      .res_data  (res_data),
      .irq_ack   (irq_ack),
      .dbg_ack   (dbg_ack),
      .bus_valid (bus_valid),
      .bus_addr  (bus_addr),
      .state     (state),
      .loaded    (loaded),
      .err       (err),
      .irq       (irq),
      .dbg_irq   (dbg_irq),
      .misr_clr  (misr_clr),
      .misr_step (misr_step),
      .ld_addr   (mem_addr),
      .ld_data   (mem_wdata)
   );

   sbst_misr #(.W(DATA_W), .POLY(POLY)) i_misr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (misr_clr),
      .step  (misr_step),
      .din   (res_data),
      .sig   (sig)
   );

   always_comb begin
      status_w       = '0;
      status_w[1:0]  = state;
      status_w[2]    = err;
      status_w[3]    = loaded;
   end

   assign rd_load = update_en && ((op == OP_STAT) || (op == OP_SIG));
   assign rd_word = (op == OP_SIG) ? sig : status_w;

   sbst_readout #(.W(DATA_W)) i_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (rd_load),
      .word     (rd_word),
      .shift_en (shift_en),
      .tdo      (tdo)
   );

   assign mem_grant = (state == ST_LOAD);
   assign mem_we    = (state == ST_LOAD);

endmodule

// File: rtl/sbst_mgr_chk.sv
module sbst_mgr_chk #(
   parameter int                DATA_W   = 16,
   parameter logic [DATA_W-1:0] END_MARK = 16'hA5C3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              update_en,
   input logic              res_we,
   input logic [DATA_W-1:0] res_data,
   input logic              irq_ack,
   input logic              dbg_ack,
   input logic              mem_grant,
   input logic              irq,
   input logic              dbg_irq,
   input logic [1:0]        st
);

   assert_grant_from_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_grant) |-> $past(update_en));

   assert_grant_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_grant |=> !mem_grant);

   assert_irq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack) |=> irq);

   assert_irq_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && irq_ack) |=> !irq);

   assert_irq_from_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(update_en));

   assert_done_on_marker_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 2'd2 && res_we && res_data == END_MARK) |=> (st == 2'd3));

   assert_dbg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_irq && !dbg_ack) |=> dbg_irq);

endmodule

bind sbst_mgr sbst_mgr_chk #(.DATA_W(DATA_W), .END_MARK(END_MARK)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .update_en (update_en),
   .res_we    (res_we),
   .res_data  (res_data),
   .irq_ack   (irq_ack),
   .dbg_ack   (dbg_ack),
   .mem_grant (mem_grant),
   .irq       (irq),
   .dbg_irq   (dbg_irq),
   .st        (state)
);

// File: tb/test_sbst_mgr.sv
module test_sbst_mgr;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam logic [DW-1:0] MARK = 16'hA5C3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tdi = 1'b0, shift_en = 1'b0, update_en = 1'b0;
   logic          tdo, mem_grant, mem_we, irq, dbg_irq;
   logic [AW-1:0] mem_addr, bus_addr = '0;
   logic [DW-1:0] mem_wdata, res_data = '0;
   logic          irq_ack = 1'b0, res_we = 1'b0, bus_valid = 1'b0, dbg_ack = 1'b0;

   int n_run  = 0;
   int n_fail = 0;
   logic [DW-1:0] model_sig = '0;

   sbst_mgr i_sbst_mgr (
      .clk(clk), .rst_n(rst_n), .tdi(tdi), .shift_en(shift_en), .update_en(update_en),
      .tdo(tdo), .mem_grant(mem_grant), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .irq(irq), .irq_ack(irq_ack), .res_we(res_we),
      .res_data(res_data), .bus_valid(bus_valid), .bus_addr(bus_addr),
      .dbg_irq(dbg_irq), .dbg_ack(dbg_ack)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] misr_next(input logic [DW-1:0] s, input logic [DW-1:0] d);
      return {s[DW-2:0], 1'b0} ^ (s[DW-1] ? 16'h1021 : 16'h0000) ^ d;
   endfunction

   task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic [2+AW+DW-1:0] f;
      f = {d, a, op};
      for (int i = 0; i < 2+AW+DW; i++) begin
         tdi = f[i]; shift_en = 1'b1;
         @(negedge clk);
      end
      shift_en = 1'b0; tdi = 1'b0; update_en = 1'b1;
      @(negedge clk);
      update_en = 1'b0;
   endtask

   task automatic read_word(input logic [1:0] op, output logic [DW-1:0] v);
      send(op, '0, '0);
      for (int i = 0; i < DW; i++) begin
         v[i] = tdo; shift_en = 1'b1;
         @(negedge clk);
      end
      shift_en = 1'b0;
   endtask

   task automatic put_result(input logic [DW-1:0] d, input bit running);
      res_data = d; res_we = 1'b1;
      @(negedge clk);
      res_we = 1'b0;
      if (running) model_sig = misr_next(model_sig, d);
   endtask

   task automatic t_reset;
      logic [DW-1:0] v;
      check("R10 grant", mem_grant, 0);
      check("R10 irq", irq, 0);
      check("R10 dbg_irq", dbg_irq, 0);
      check("R10 tdo", tdo, 0);
      read_word(2'd2, v);
      check("R10 R8 status", v, 0);
      read_word(2'd3, v);
      check("R10 signature", v, 0);
   endtask

   task automatic t_early_run;
      logic [DW-1:0] v;
      send(2'd1, 16'h0040, 16'h0001);
      check("R7 irq", irq, 0);
      read_word(2'd2, v);
      check("R7 R8 status err", v, 16'h0004);
   endtask

   task automatic t_load;
      logic [DW-1:0] v;
      send(2'd0, 16'h0123, 16'hBEEF);
      check("R2 grant", mem_grant, 1);
      check("R2 we", mem_we, 1);
      check("R2 addr", mem_addr, 16'h0123);
      check("R2 data", mem_wdata, 16'hBEEF);
      @(negedge clk);
      check("R2 grant drop", mem_grant, 0);
      read_word(2'd2, v);
      check("R8 status loaded", v, 16'h000C);
   endtask

   task automatic t_run;
      logic [DW-1:0] v;
      send(2'd1, 16'h0040, 16'h0001);
      model_sig = '0;
      check("R3 irq rise", irq, 1);
      repeat (3) @(negedge clk);
      check("R3 irq held", irq, 1);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      check("R3 irq cleared", irq, 0);
      read_word(2'd2, v);
      check("R8 R7 status running", v, 16'h000A);
      send(2'd0, 16'h0200, 16'h1111);
      check("R2 load during run ignored", mem_grant, 0);
   endtask

   task automatic t_debug;
      bus_valid = 1'b1; bus_addr = 16'h0041;
      @(negedge clk);
      check("R9 no match", dbg_irq, 0);
      bus_addr = 16'h0040;
      @(negedge clk);
      bus_valid = 1'b0;
      check("R9 match fires", dbg_irq, 1);
      @(negedge clk);
      check("R9 held", dbg_irq, 1);
      dbg_ack = 1'b1;
      @(negedge clk);
      dbg_ack = 1'b0;
      check("R9 acked", dbg_irq, 0);
      bus_valid = 1'b1;
      @(negedge clk);
      bus_valid = 1'b0;
      @(negedge clk);
      check("R9 disarmed", dbg_irq, 0);
   endtask

   task automatic t_results;
      logic [DW-1:0] v;
      put_result(16'h8001, 1);
      put_result(16'h1234, 1);
      put_result(16'hFFFF, 1);
      read_word(2'd3, v);
      check("R6 R4 partial signature", v, model_sig);
      read_word(2'd2, v);
      check("R6 run undisturbed", v, 16'h000A);
      put_result(16'h0F0F, 1);
      put_result(MARK, 1);
      read_word(2'd2, v);
      check("R5 done status", v, 16'h000B);
      read_word(2'd3, v);
      check("R5 R4 final signature", v, model_sig);
      put_result(16'h7777, 0);
      read_word(2'd3, v);
      check("R4 write after done ignored", v, model_sig);
   endtask

   task automatic t_rerun;
      logic [DW-1:0] v;
      send(2'd1, 16'h0000, 16'h0000);
      model_sig = '0;
      check("R3 rerun irq", irq, 1);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      read_word(2'd3, v);
      check("R4 cleared on run", v, 16'h0000);
      put_result(16'h0001, 1);
      read_word(2'd3, v);
      check("R4 single step", v, 16'h0001);
      check("R1 R9 unarmed run", dbg_irq, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_early_run();
      t_load();
      t_run();
      t_debug();
      t_results();
      t_rerun();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule